// File: doc/BRIEF.md
# Push-Pull Gate Sequencer with Short Flag

This block sits between the commanded level of a bank of push-pull outputs and the gate drivers of those outputs. For each channel it turns the commanded bit into a high-side enable and a low-side enable. Whenever a channel's command changes, it first turns both gates off and holds them off for a set number of clock cycles. Only then does it enable the gate for the new level. This prevents any cross-conduction. A tri-state command parks every channel with both gates off.

Each channel also reports a sensed output level. The block compares that level with the command on every channel that is not tri-stated, and ORs the per-channel results into a single mismatch signal. That signal is then qualified in time, with separate delays for asserting and for clearing, before it drives the shared active-low short flag. A real fault pulls the flag low after a fixed number of cycles and releases it after another fixed number of clean cycles. A slow but normal output transition makes the flag pulse low briefly. All delays are counted in clock cycles.

Top module: `bbm_short_top`

## Requirements
- R1: On no channel are `hsEn` and `lsEn` both high in any cycle.
- R2: A clock edge at which a channel's command differs from its current target turns both gates of that channel off. Both stay off for exactly DEAD_CYC cycles. After that, `hsEn`=1 if the new command is 1, or `lsEn`=1 if it is 0. A further change during the off interval restarts the interval.
- R3: While a channel's command is steady and its dead time has elapsed, `hsEn` equals the command bit and `lsEn` equals its inverse.
- R4: The first edge that sees `hiZ`=1 turns both gates of every channel off. Once `hiZ` returns to 0, each channel drives again at the DEAD_CYC-th edge after the last edge that saw `hiZ`=1.
- R5: During reset all gates are off and `shortN` is 1, and every channel's target is low. A channel commanded low enables `lsEn` at the DEAD_CYC-th edge after reset is released.
- R6: A channel mismatches when `hiZ`=0 and its `sense` bit differs from its `cmdState` bit. `shortN` falls at the ASSERT_CYC-th consecutive edge at which at least one channel mismatches.
- R7: A run of fewer than ASSERT_CYC consecutive mismatch edges leaves `shortN` high. This covers a normal transition in which `sense` follows `hsEn` with no lag, which produces DEAD_CYC+1 mismatch edges.
- R8: Once low, `shortN` rises at the CLEAR_CYC-th consecutive edge with no mismatch. A single mismatch edge restarts that count.
- R9: While `hiZ`=1, no difference between `sense` and `cmdState` can pull `shortN` low.
- R10: A mismatch on any single channel is enough to drive `shortN` low (channels are ORed).
- R11: If the sensed level lags a commanded change by more than ASSERT_CYC edges, `shortN` pulses low. It rises again CLEAR_CYC edges after the sensed level matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdState | input | NUM_CH | Commanded output level per channel |
| hiZ | input | 1 | Tri-state command: all gates off, comparison disabled |
| sense | input | NUM_CH | Sensed output level per channel |
| hsEn | output | NUM_CH | High-side gate enable per channel |
| lsEn | output | NUM_CH | Low-side gate enable per channel |
| shortN | output | 1 | Active-low flag for a qualified mismatch |

## Verification
The bench reverses a command while that channel is still in its off interval. A design that kept the first off interval instead of restarting it would turn the low-side gate on too early. The bench also presents a mismatch one edge short of the assert delay, and breaks a clear run with a single mismatch edge. An off-by-one counter would drop the flag on the short run, or release it on the original schedule after the break. Finally, the bench disagrees `sense` with the command while tri-stated, and runs a single-channel fault. A design that skipped the tri-state mask would raise a false short, and one that ANDed the channels would miss the fault.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  // per-channel strobes from control to datapath
  typedef struct packed {
    logic reload;  // latch a new target, gates off
    logic drive;   // dead time over, enable gate for target
  } chStrobe_t;

  // short flag strobes
  typedef struct packed {
    logic flagSet;  // pull shortN low
    logic flagClr;  // release shortN
  } flagStrobe_t;
endpackage

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
  import bbm_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned DEAD_CYC   = 3,
  parameter int unsigned ASSERT_CYC = 5,
  parameter int unsigned CLEAR_CYC  = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chChange,
  input  logic                     anyMis,
  input  logic                     shortN,
  output chStrobe_t [NUM_CH-1:0]   chStb,
  output flagStrobe_t              flagStb
);
  localparam int unsigned DW   = $clog2(DEAD_CYC + 1);
  localparam int unsigned QMAX = (ASSERT_CYC > CLEAR_CYC) ? ASSERT_CYC : CLEAR_CYC;
  localparam int unsigned QW   = $clog2(QMAX + 1);

  // dead-time counter per channel
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dead
    logic [DW-1:0] deadCnt;
    always_ff @(posedge clk) begin
      if (!rstN || chChange[i]) deadCnt <= DW'(DEAD_CYC - 1);
      else if (deadCnt != '0)   deadCnt <= deadCnt - 1'b1;
    end
    assign chStb[i].reload = chChange[i];
    assign chStb[i].drive  = !chChange[i] && (deadCnt == '0);
  end

  // asymmetric qualification of the ORed mismatch
  logic          runCond;
  logic          hit;
  logic [QW-1:0] qualCnt;
  logic [QW-1:0] limit;

  assign runCond = shortN ? anyMis : !anyMis;
  assign limit   = shortN ? QW'(ASSERT_CYC - 1) : QW'(CLEAR_CYC - 1);
  assign hit     = runCond && (qualCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN || !runCond || hit) qualCnt <= '0;
    else                          qualCnt <= qualCnt + 1'b1;
  end

  assign flagStb.flagSet = hit && shortN;
  assign flagStb.flagClr = hit && !shortN;

  // R6
  fall_needs_mis_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shortN) |-> $past(anyMis));
  // R8
  rise_needs_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortN) |-> !$past(anyMis));
endmodule

// File: rtl/bbm_dp.sv
module bbm_dp
  import bbm_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hiZ,
  input  logic [NUM_CH-1:0]      cmdState,
  input  logic [NUM_CH-1:0]      sense,
  input  chStrobe_t [NUM_CH-1:0] chStb,
  input  flagStrobe_t            flagStb,
  output logic [NUM_CH-1:0]      chChange,
  output logic                   anyMis,
  output logic [NUM_CH-1:0]      hsEn,
  output logic [NUM_CH-1:0]      lsEn,
  output logic                   shortN
);
  logic [NUM_CH-1:0] tgt;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chChange[i] = hiZ || (cmdState[i] != tgt[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        tgt[i]  <= 1'b0;
        hsEn[i] <= 1'b0;
        lsEn[i] <= 1'b0;
      end else begin
        if (chStb[i].reload) tgt[i] <= cmdState[i];
        hsEn[i] <= chStb[i].drive && tgt[i];
        lsEn[i] <= chStb[i].drive && !tgt[i];
      end
    end

    // R2
    reload_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      chStb[i].reload |=> (!hsEn[i] && !lsEn[i]));
  end

  assign anyMis = !hiZ && (|(sense ^ cmdState));

  always_ff @(posedge clk) begin
    if (!rstN)                shortN <= 1'b1;
    else if (flagStb.flagSet) shortN <= 1'b0;
    else if (flagStb.flagClr) shortN <= 1'b1;
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsEn & lsEn) == '0);
  // R4
  hiz_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiZ |=> (hsEn == '0 && lsEn == '0));
  // R9
  hiz_no_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hiZ && shortN) |=> shortN);
endmodule

// File: rtl/bbm_short_top.sv
module bbm_short_top
  import bbm_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned DEAD_CYC   = 3,
  parameter int unsigned ASSERT_CYC = 5,
  parameter int unsigned CLEAR_CYC  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdState,
  input  logic              hiZ,
  input  logic [NUM_CH-1:0] sense,
  output logic [NUM_CH-1:0] hsEn,
  output logic [NUM_CH-1:0] lsEn,
  output logic              shortN
);
  chStrobe_t [NUM_CH-1:0] chStb;
  flagStrobe_t            flagStb;
  logic [NUM_CH-1:0]      chChange;
  logic                   anyMis;

  bbm_ctrl #(
    .NUM_CH(NUM_CH), .DEAD_CYC(DEAD_CYC),
    .ASSERT_CYC(ASSERT_CYC), .CLEAR_CYC(CLEAR_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chChange(chChange), .anyMis(anyMis),
    .shortN(shortN), .chStb(chStb), .flagStb(flagStb)
  );

  bbm_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .hiZ(hiZ), .cmdState(cmdState), .sense(sense),
    .chStb(chStb), .flagStb(flagStb), .chChange(chChange), .anyMis(anyMis),
    .hsEn(hsEn), .lsEn(lsEn), .shortN(shortN)
  );
endmodule

// File: tb/bbm_short_top_bench.sv
module bbm_short_top_bench;
  localparam int N = 8;
  localparam int D = 3;
  localparam int A = 5;
  localparam int C = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] cmdState = '0;
  logic hiZ = 1'b0;
  logic senseManual = 1'b0;
  logic [N-1:0] senseVal = '0;
  logic [N-1:0] sense, hsEn, lsEn;
  logic shortN;
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sense = senseManual ? senseVal : hsEn;

  bbm_short_top #(.NUM_CH(N), .DEAD_CYC(D), .ASSERT_CYC(A), .CLEAR_CYC(C)) u_bbm_short_top (
    .clk(clk), .rstN(rstN), .cmdState(cmdState), .hiZ(hiZ), .sense(sense),
    .hsEn(hsEn), .lsEn(lsEn), .shortN(shortN)
  );

  typedef struct {
    int       at;
    bit       chkG;
    logic [N-1:0] hs;
    logic [N-1:0] ls;
    bit       chkS;
    logic     sh;
    string    tag;
  } item_t;
  item_t q[$];

  task automatic expG(int at, logic [N-1:0] hs, logic [N-1:0] ls, string tag);
    item_t it;
    it.at = at; it.chkG = 1; it.hs = hs; it.ls = ls; it.chkS = 0; it.sh = 1'b1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expS(int at, logic sh, string tag);
    item_t it;
    it.at = at; it.chkG = 0; it.hs = '0; it.ls = '0; it.chkS = 1; it.sh = sh; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  // monitor: pops expectations away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      nChecks++;
      if ((hsEn & lsEn) != '0) begin
        nFails++;
        $display("FAIL R1 cyc %0d overlap hs=%h ls=%h expected no common bit", cyc, hsEn, lsEn);
      end
      while (q.size() > 0 && q[0].at <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.chkG) begin
          nChecks++;
          if (hsEn !== it.hs || lsEn !== it.ls) begin
            nFails++;
            $display("FAIL %s cyc %0d gates hs=%h ls=%h expected hs=%h ls=%h",
                     it.tag, cyc, hsEn, lsEn, it.hs, it.ls);
          end
        end
        if (it.chkS) begin
          nChecks++;
          if (shortN !== it.sh) begin
            nFails++;
            $display("FAIL %s cyc %0d shortN=%b expected %b", it.tag, cyc, shortN, it.sh);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog expired, queue=%0d expected 0", q.size());
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int t;
    // R5: reset state
    step(1);
    t = cyc;
    expG(t + 1, 8'h00, 8'h00, "R5");
    expS(t + 1, 1'b1, "R5");
    step(3);
    rstN = 1'b1;
    t = cyc;
    expG(t + 1, 8'h00, 8'h00, "R5");
    expG(t + 2, 8'h00, 8'h00, "R5");
    expG(t + 3, 8'h00, 8'hFF, "R5");
    expS(t + 3, 1'b1, "R5");
    step(6);

    // R2/R3/R7: normal change, sense tracks with no lag
    cmdState = 8'h0F;
    t = cyc;
    expG(t + 1, 8'h00, 8'hF0, "R2");
    expG(t + 3, 8'h00, 8'hF0, "R2");
    expG(t + 4, 8'h0F, 8'hF0, "R2");
    expS(t + 4, 1'b1, "R7");
    expS(t + 6, 1'b1, "R7");
    expG(t + 7, 8'h0F, 8'hF0, "R3");
    step(8);

    // R2: reversal during the off interval restarts it
    cmdState = 8'hFF;
    t = cyc;
    step(1);
    cmdState = 8'h0F;
    expG(t + 1, 8'h0F, 8'h00, "R2");
    expG(t + 4, 8'h0F, 8'h00, "R2");
    expG(t + 5, 8'h0F, 8'hF0, "R2");
    step(8);

    // R4/R9: tri-state parks gates and masks comparison
    hiZ = 1'b1;
    t = cyc;
    expG(t + 1, 8'h00, 8'h00, "R4");
    expG(t + 2, 8'h00, 8'h00, "R4");
    step(2);
    senseManual = 1'b1;
    senseVal = 8'hAA;
    expS(t + 8, 1'b1, "R9");
    expS(t + 10, 1'b1, "R9");
    step(8);
    t = cyc;
    hiZ = 1'b0;
    senseManual = 1'b0;
    expG(t + 1, 8'h00, 8'h00, "R4");
    expG(t + 2, 8'h00, 8'h00, "R4");
    expG(t + 3, 8'h0F, 8'hF0, "R4");
    expS(t + 5, 1'b1, "R4");
    step(8);

    // R6/R10/R8: single channel fault, then clear
    senseManual = 1'b1;
    senseVal = 8'h4F;
    t = cyc;
    expS(t + 4, 1'b1, "R6");
    expS(t + 5, 1'b0, "R10");
    expG(t + 5, 8'h0F, 8'hF0, "R3");
    step(7);
    senseVal = 8'h0F;
    expS(t + 12, 1'b0, "R8");
    expS(t + 13, 1'b1, "R8");
    step(10);

    // R8: a single mismatch edge restarts the clear count
    senseVal = 8'h0E;
    t = cyc;
    expS(t + 5, 1'b0, "R6");
    step(6);
    senseVal = 8'h0F;
    step(3);
    senseVal = 8'h0E;
    step(1);
    senseVal = 8'h0F;
    expS(t + 12, 1'b0, "R8");
    expS(t + 15, 1'b0, "R8");
    expS(t + 16, 1'b1, "R8");
    step(10);

    // R7: mismatch one edge short of the assert delay
    senseVal = 8'h2F;
    t = cyc;
    step(4);
    senseVal = 8'h0F;
    expS(t + 4, 1'b1, "R7");
    expS(t + 7, 1'b1, "R7");
    step(6);

    // R11: slow transition produces a low pulse
    cmdState = 8'hFF;
    t = cyc;
    expG(t + 4, 8'hFF, 8'h00, "R2");
    expS(t + 4, 1'b1, "R11");
    expS(t + 5, 1'b0, "R11");
    step(8);
    senseVal = 8'hFF;
    expS(t + 13, 1'b0, "R11");
    expS(t + 14, 1'b1, "R11");
    step(10);

    while (q.size() > 0) step(1);
    step(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule